// File: doc/BRIEF.md
# Shift-Add YUV to RGB Colour Converter

This block turns a stream of 8-bit unsigned luma and chroma samples (Y, U, V) into 8-bit unsigned red, green and blue values ready for a digital display transmitter. Each chroma sample is first re-centred around zero by removing its mid-scale bias of 128. The fixed conversion coefficients are then applied using only arithmetic right shifts and additions, so the datapath contains no hardware multipliers. All intermediate values are held as 12-bit signed numbers. Each final channel is saturated into the range 0 to 255.

The interface is a plain streaming one. The source raises `in_valid` together with one pixel. The pixel appears on the outputs with `out_valid` a fixed number of cycles later. A new pixel may be accepted on every clock. When no pixel is offered, every pipeline register keeps its contents, so the outputs hold the last converted pixel.

Top module: `yuv2rgb_shiftadd`

## Requirements
- R1: A pixel presented with `in_valid` high at a rising clock edge appears on the outputs with `out_valid` high after exactly 3 rising edges (the capturing edge counted). Back-to-back pixels stream out one per cycle.
- R2: A synchronous reset (`rst_n` low at a rising edge) clears `out_valid` and drives `out_r`, `out_g` and `out_b` to 0.
- R3: With d = U − 128 and e = V − 128, the unclamped red value is Y + e + (e>>>2) + (e>>>3) + (e>>>5). Each `>>>` is an arithmetic shift that rounds toward minus infinity.
- R4: The unclamped green value is Y − [(d>>>2) + (d>>>4) + (d>>>5)] − [(e>>>1) + (e>>>3) + (e>>>4) + (e>>>5)].
- R5: The unclamped blue value is Y + d + (d>>>1) + (d>>>2) + (d>>>6).
- R6: Any unclamped channel value above 255 is output as 255.
- R7: Any unclamped channel value below 0 is output as 0.
- R8: With neutral chroma (U = V = 128), all three outputs equal Y.
- R9: While no pixel is moving through the last stage, `out_r`, `out_g` and `out_b` keep their previous values, and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers capture on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | High when `in_y`, `in_u` and `in_v` carry a pixel |
| in_y | input | 8 | Luma sample, unsigned |
| in_u | input | 8 | Blue-difference chroma sample, unsigned with a bias of 128 |
| in_v | input | 8 | Red-difference chroma sample, unsigned with a bias of 128 |
| out_valid | output | 1 | High when `out_r`, `out_g` and `out_b` carry a newly converted pixel |
| out_r | output | 8 | Red result, saturated |
| out_g | output | 8 | Green result, saturated |
| out_b | output | 8 | Blue result, saturated |

## Verification
Some properties are checked on every clock:
- the three-cycle timing of `out_valid` against `in_valid`;
- the cleared state after reset;
- the frozen outputs during bubbles;
- saturation, by relating each channel's unclamped sum to the registered output one cycle later.

The shift-and-add arithmetic itself can only be shown by the bench scenarios. These feed pixels whose exact results were worked out by hand, including pixels that drive channels past both ends of the range and pixels with negative chroma offsets where floor rounding of the shifts matters. The bench also shows correct ordering of pixels in back-to-back streams and in streams with gaps.

// File: rtl/yuv2rgb_pkg.sv
package yuv2rgb_pkg;

  localparam int PIX_W   = 8;
  localparam int MID_W   = 12;
  localparam int NCH     = 3;
  localparam int PIX_MAX = (1 << PIX_W) - 1;
  localparam int BIAS    = 1 << (PIX_W - 1);

  typedef logic        [PIX_W-1:0] pix_t;
  typedef logic signed [MID_W-1:0] mid_t;

  typedef enum int {CH_R = 0, CH_G = 1, CH_B = 2} chan_e;

  // Remove the mid-scale bias from a chroma sample.
  function automatic mid_t center(input pix_t c);
    return mid_t'({{(MID_W-PIX_W){1'b0}}, c}) - mid_t'(BIAS);
  endfunction

  // Widen luma into the signed intermediate format.
  function automatic mid_t widen(input pix_t y);
    return mid_t'({{(MID_W-PIX_W){1'b0}}, y});
  endfunction

  // About 1.406 * e
  function automatic mid_t red_term(input mid_t e);
    return e + (e >>> 2) + (e >>> 3) + (e >>> 5);
  endfunction

  // About 0.344 * d
  function automatic mid_t green_u_term(input mid_t d);
    return (d >>> 2) + (d >>> 4) + (d >>> 5);
  endfunction

  // About 0.719 * e
  function automatic mid_t green_v_term(input mid_t e);
    return (e >>> 1) + (e >>> 3) + (e >>> 4) + (e >>> 5);
  endfunction

  // About 1.766 * d
  function automatic mid_t blue_term(input mid_t d);
    return d + (d >>> 1) + (d >>> 2) + (d >>> 6);
  endfunction

  // Saturate a signed intermediate into the unsigned pixel range.
  function automatic pix_t saturate(input mid_t s);
    if (s < 0)
      return '0;
    else if (s > mid_t'(PIX_MAX))
      return pix_t'(PIX_MAX);
    else
      return s[PIX_W-1:0];
  endfunction

endpackage

// File: rtl/yuv2rgb_center.sv
module yuv2rgb_center
  import yuv2rgb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vld_i,
  input  pix_t y_i,
  input  pix_t u_i,
  input  pix_t v_i,
  output logic vld_o,
  output pix_t y_o,
  output mid_t d_o,
  output mid_t e_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      y_o   <= '0;
      d_o   <= '0;
      e_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        y_o <= y_i;
        d_o <= center(u_i);
        e_o <= center(v_i);
      end
    end
  end

endmodule

// File: rtl/yuv2rgb_terms.sv
module yuv2rgb_terms
  import yuv2rgb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vld_i,
  input  pix_t y_i,
  input  mid_t d_i,
  input  mid_t e_i,
  output logic vld_o,
  output pix_t y_o,
  output mid_t add_o [NCH]
);

  mid_t add_c [NCH];

  always_comb begin
    add_c[CH_R] = red_term(e_i);
    add_c[CH_G] = -(green_u_term(d_i) + green_v_term(e_i));
    add_c[CH_B] = blue_term(d_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      y_o   <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) y_o <= y_i;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_term
    always_ff @(posedge clk) begin
      if (!rst_n)     add_o[c] <= '0;
      else if (vld_i) add_o[c] <= add_c[c];
    end
  end

endmodule

// File: rtl/yuv2rgb_sat.sv
module yuv2rgb_sat
  import yuv2rgb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  pix_t y_i,
  input  mid_t add_i,
  output mid_t sum_o,
  output pix_t pix_o
);

  assign sum_o = widen(y_i) + add_i;

  always_ff @(posedge clk) begin
    if (!rst_n)    pix_o <= '0;
    else if (en_i) pix_o <= saturate(sum_o);
  end

endmodule

// File: rtl/yuv2rgb_shiftadd.sv
module yuv2rgb_shiftadd
  import yuv2rgb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_y,
  input  logic [7:0] in_u,
  input  logic [7:0] in_v,
  output logic       out_valid,
  output logic [7:0] out_r,
  output logic [7:0] out_g,
  output logic [7:0] out_b
);

  logic s1_valid;
  pix_t s1_y;
  mid_t s1_d, s1_e;

  logic s2_valid;
  pix_t s2_y;
  mid_t s2_add [NCH];

  mid_t sum_ch [NCH];
  pix_t pix_ch [NCH];

  // Named sums for the checker
  mid_t sum_r, sum_g, sum_b;

  yuv2rgb_center u_center (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (in_valid),
    .y_i   (in_y),
    .u_i   (in_u),
    .v_i   (in_v),
    .vld_o (s1_valid),
    .y_o   (s1_y),
    .d_o   (s1_d),
    .e_o   (s1_e)
  );

  yuv2rgb_terms u_terms (
    .clk   (clk),
    .rst_n (rst_n),
    .vld_i (s1_valid),
    .y_i   (s1_y),
    .d_i   (s1_d),
    .e_i   (s1_e),
    .vld_o (s2_valid),
    .y_o   (s2_y),
    .add_o (s2_add)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    yuv2rgb_sat u_sat (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (s2_valid),
      .y_i   (s2_y),
      .add_i (s2_add[c]),
      .sum_o (sum_ch[c]),
      .pix_o (pix_ch[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= s2_valid;
  end

  assign sum_r = sum_ch[CH_R];
  assign sum_g = sum_ch[CH_G];
  assign sum_b = sum_ch[CH_B];
  assign out_r = pix_ch[CH_R];
  assign out_g = pix_ch[CH_G];
  assign out_b = pix_ch[CH_B];

endmodule

// File: rtl/yuv2rgb_shiftadd_sva.sv
module yuv2rgb_shiftadd_sva
  import yuv2rgb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       s2_valid,
  input mid_t       sum_r,
  input mid_t       sum_g,
  input mid_t       sum_b,
  input logic       out_valid,
  input logic [7:0] out_r,
  input logic [7:0] out_g,
  input logic [7:0] out_b
);

  // Counts edges since reset, up to 3
  logic [1:0] run_cnt = 2'd0;
  always_ff @(posedge clk) begin
    if (!rst_n)               run_cnt <= 2'd0;
    else if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
  end

  // R1: out_valid follows in_valid by exactly three edges
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_cnt == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R2: reset clears valid and data
  p_reset_clear_r2: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && out_r == 8'd0 && out_g == 8'd0 && out_b == 8'd0));

  // R9: outputs frozen while nothing moves through the last stage
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_valid |=> ($stable({out_r, out_g, out_b}) && !out_valid));

  // R6: saturation at the top of the range
  p_sat_hi_r_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && sum_r > mid_t'(PIX_MAX)) |=> (out_r == 8'd255));
  p_sat_hi_g_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && sum_g > mid_t'(PIX_MAX)) |=> (out_g == 8'd255));
  p_sat_hi_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && sum_b > mid_t'(PIX_MAX)) |=> (out_b == 8'd255));

  // R7: saturation at the bottom of the range
  p_sat_lo_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && sum_r < 0) |=> (out_r == 8'd0));
  p_sat_lo_g_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && sum_g < 0) |=> (out_g == 8'd0));
  p_sat_lo_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && sum_b < 0) |=> (out_b == 8'd0));

endmodule

bind yuv2rgb_shiftadd yuv2rgb_shiftadd_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .s2_valid  (s2_valid),
  .sum_r     (sum_r),
  .sum_g     (sum_g),
  .sum_b     (sum_b),
  .out_valid (out_valid),
  .out_r     (out_r),
  .out_g     (out_g),
  .out_b     (out_b)
);

// File: tb/yuv2rgb_shiftadd_tb.sv
module yuv2rgb_shiftadd_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_y = '0, in_u = '0, in_v = '0;
  logic       out_valid;
  logic [7:0] out_r, out_g, out_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  yuv2rgb_shiftadd u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_y      (in_y),
    .in_u      (in_u),
    .in_v      (in_v),
    .out_valid (out_valid),
    .out_r     (out_r),
    .out_g     (out_g),
    .out_b     (out_b)
  );

  // {y, u, v, r, g, b}: expected results worked out by hand from R3..R8
  localparam int NV = 8;
  localparam logic [47:0] VEC [NV] = '{
    {8'd100, 8'd128, 8'd128, 8'd100, 8'd100, 8'd100}, // R8 neutral
    {8'd0,   8'd128, 8'd128, 8'd0,   8'd0,   8'd0  }, // R8 black
    {8'd255, 8'd255, 8'd255, 8'd255, 8'd126, 8'd255}, // R6 r,b high
    {8'd0,   8'd0,   8'd0,   8'd0,   8'd136, 8'd0  }, // R7 r,b low
    {8'd128, 8'd128, 8'd192, 8'd218, 8'd82,  8'd128}, // R3 R4
    {8'd128, 8'd64,  8'd128, 8'd128, 8'd150, 8'd15 }, // R4 R5
    {8'd50,  8'd200, 8'd60,  8'd0,   8'd77,  8'd177}, // R3 R7 floor
    {8'd200, 8'd20,  8'd240, 8'd255, 8'd158, 8'd9  }  // R6 R5 floor
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_pix(input string req, input int idx);
    check({req, " red"},   32'(out_r), 32'(VEC[idx][23:16]));
    check({req, " green"}, 32'(out_g), 32'(VEC[idx][15:8]));
    check({req, " blue"},  32'(out_b), 32'(VEC[idx][7:0]));
    check({req, " valid"}, 32'(out_valid), 32'd1);
  endtask

  task automatic drive(input int idx);
    in_valid = 1'b1;
    in_y = VEC[idx][47:40];
    in_u = VEC[idx][39:32];
    in_v = VEC[idx][31:24];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 valid after reset", 32'(out_valid), 32'd0);
    check("R2 red after reset", 32'(out_r), 32'd0);
    check("R2 green after reset", 32'(out_g), 32'd0);
    check("R2 blue after reset", 32'(out_b), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: back-to-back stream, R1 throughput and R3..R8 values
    for (int n = 0; n < NV + 3; n++) begin
      if (n >= 3) check_pix("R1 stream", n - 3);
      if (n < NV) drive(n);
      else in_valid = 1'b0;
      @(negedge clk);
    end

    // R9: outputs hold the last pixel during idle cycles
    repeat (4) @(negedge clk);
    check("R9 hold red", 32'(out_r), 32'(VEC[NV-1][23:16]));
    check("R9 hold green", 32'(out_g), 32'(VEC[NV-1][15:8]));
    check("R9 hold blue", 32'(out_b), 32'(VEC[NV-1][7:0]));
    check("R9 valid idle", 32'(out_valid), 32'd0);

    // R1: single pulse, valid exactly three edges later
    drive(4);
    @(negedge clk);
    in_valid = 1'b0;
    in_y = 8'd7; in_u = 8'd0; in_v = 8'd255;  // ignored: valid low
    check("R1 not after one edge", 32'(out_valid), 32'd0);
    @(negedge clk);
    check("R1 not after two edges", 32'(out_valid), 32'd0);
    @(negedge clk);
    check_pix("R1 single pulse R3 R4", 4);
    @(negedge clk);
    check("R1 one cycle only", 32'(out_valid), 32'd0);
    check("R9 ignored input red", 32'(out_r), 32'(VEC[4][23:16]));

    // R1: stream with gaps, order preserved
    for (int n = 0; n < 12; n++) begin
      if (n == 3) check_pix("R1 gapped first R5", 5);
      if (n == 5) check_pix("R1 gapped second R7", 6);
      if (n == 6) check("R9 gap valid", 32'(out_valid), 32'd0);
      if (n == 8) check_pix("R1 gapped third R6", 2);
      if (n == 0) drive(5);
      else if (n == 2) drive(6);
      else if (n == 5) drive(2);
      else in_valid = 1'b0;
      @(negedge clk);
    end

    // R2: reset in mid-stream discards pixels in flight
    drive(3);
    @(negedge clk);
    drive(7);
    rst_n = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b1;
    check("R2 mid reset valid", 32'(out_valid), 32'd0);
    check("R2 mid reset red", 32'(out_r), 32'd0);
    repeat (3) @(negedge clk);
    check("R2 flushed valid", 32'(out_valid), 32'd0);
    check("R2 flushed green", 32'(out_g), 32'd0);

    // R8: neutral chroma after reset
    drive(0);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check_pix("R8 neutral", 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule